// File: doc/BRIEF.md
# Two-Level Framer Interrupt Aggregator

This block gathers interrupt requests from three places in a framer: a receive section, a transmit section and a one-second timer. It presents them to a host over a byte-wide register bus and drives one active-high interrupt line. The receive and transmit sections each hold their own per-source enable and pending registers. The block level has one enable register and one status register. In the status register, the receive and transmit bits only summarise their sections. The one-second bit is latched at block level.

The host handles an interrupt in two steps. It first reads the block status register to find out which section raised the interrupt. It then reads that section's pending register, and this read clears the pending bits. The read of the block status register clears the one-second bit by itself. A one-second tick comes from a reference-clock divider set by `CLK_HZ`.

The register map is as follows. The block enable register is at 0x04 and the block status register is at 0x05. The receive source enable register is at 0x10 and the receive pending register is at 0x11. The transmit source enable register is at 0x12 and the transmit pending register is at 0x13. Both block registers use bit 7 for receive, bit 1 for transmit and bit 0 for the one-second timer. Source register bit i belongs to event input bit i.

Top module: `frm_irq_agg`

## Requirements
- R1: After reset, the block status register (0x05) reads 0x01, and every block and source enable register reads 0x00.
- R2: Block status bits 6 down to 2 always read 0. A host write to 0x05 has no effect on the register.
- R3: Status bit 7 reads 1 while any enabled receive source is pending. A read of the receive pending register (0x11) returns the pending bits and clears them, and bit 7 then returns to 0.
- R4: Status bit 1 behaves the same way for the transmit section, using the transmit pending register (0x13).
- R5: An event on a source whose source enable bit is 0 is not latched. Its pending bit stays 0 and the section summary bit is unaffected.
- R6: `irq_o` is the OR, over bits 7, 1 and 0, of block status AND block enable. Block enable bit 0 at 7 or 1 masks that section's interrupt. Block enable bit 1 alone raises nothing unless a source is pending.
- R7: Status bit 0 is set by a one-second tick only while block enable bit 0 is 1. It clears on the clock edge that ends a read strobe to 0x05.
- R8: While enabled, one-second ticks are exactly `CLK_HZ` clock cycles apart.
- R9: If a tick arrives on the same edge as the clearing read of 0x05, bit 0 stays 1.
- R10: A source event that arrives on the same edge as the clearing read of its pending register stays pending.
- R11: Enable registers read back the value last written to them. A read strobe returns data on the next clock edge and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe, one cycle |
| rd_data_o | output | 8 | Registered read data |
| rx_evt_i | input | RX_N | Receive source event pulses |
| tx_evt_i | input | TX_N | Transmit source event pulses |
| irq_o | output | 1 | Combined interrupt request |

## Verification
On every cycle, the embedded assertions check four behaviours. An enabled source event is latched. A clearing read with no new event empties the pending register. A tick with the one-second enable set leaves bit 0 set, and with the enable clear bit 0 cannot rise. A rise of the interrupt line requires some block enable. Other behaviours appear only in the directed scenarios: the exact tick spacing, the reset-on-read value seen by the host, the coincident tick or event during a clearing read, and the veto of an enabled source by a cleared block enable.

// File: rtl/frm_irq_pkg.sv
package frm_irq_pkg;
  localparam int DATA_W = 8;

  localparam logic [7:0] A_BLK_EN = 8'h04;
  localparam logic [7:0] A_BLK_ST = 8'h05;
  localparam logic [7:0] A_RX_EN  = 8'h10;
  localparam logic [7:0] A_RX_ST  = 8'h11;
  localparam logic [7:0] A_TX_EN  = 8'h12;
  localparam logic [7:0] A_TX_ST  = 8'h13;

  localparam int B_RX  = 7;
  localparam int B_TX  = 1;
  localparam int B_SEC = 0;

  typedef struct packed {
    logic rx;
    logic tx;
    logic sec;
  } blk_bits_t;

  function automatic logic [DATA_W-1:0] pack_blk(blk_bits_t b);
    logic [DATA_W-1:0] r;
    r        = '0;
    r[B_RX]  = b.rx;
    r[B_TX]  = b.tx;
    r[B_SEC] = b.sec;
    return r;
  endfunction

  function automatic blk_bits_t unpack_blk(logic [DATA_W-1:0] d);
    blk_bits_t b;
    b.rx  = d[B_RX];
    b.tx  = d[B_TX];
    b.sec = d[B_SEC];
    return b;
  endfunction
endpackage

// File: rtl/frm_irq_tick.sv
module frm_irq_tick #(
  parameter int CLK_HZ = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_HZ - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = wrap;

  generate
    if (CLK_HZ > 1) begin : g_gap
      // R8
      tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/frm_irq_src.sv
module frm_irq_src #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_wdata_i,
  input  logic         rd_clr_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] pend_o,
  output logic         req_o
);
  logic [N-1:0] en_q, en_d;
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] hit;

  always_comb begin
    hit    = evt_i & en_q;
    en_d   = en_wr_i ? en_wdata_i : en_q;
    pend_d = (rd_clr_i ? '0 : pend_q) | hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign req_o  = |(pend_q & en_q);

  // R10
  src_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & en_q) != '0) |=> ((pend_q & $past(evt_i & en_q)) == $past(evt_i & en_q)));

  // R3
  src_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && ((evt_i & en_q) == '0)) |=> (pend_q == '0));
endmodule

// File: rtl/frm_irq_blk.sv
module frm_irq_blk
  import frm_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_wr_i,
  input  blk_bits_t en_wdata_i,
  input  logic      tick_i,
  input  logic      rd_clr_i,
  input  logic      rx_req_i,
  input  logic      tx_req_i,
  output blk_bits_t en_o,
  output blk_bits_t stat_o,
  output logic      irq_o
);
  blk_bits_t en_q, en_d;
  logic      sec_q, sec_d;
  blk_bits_t stat;

  always_comb begin
    en_d  = en_wr_i ? en_wdata_i : en_q;
    sec_d = (rd_clr_i ? 1'b0 : sec_q) | (tick_i & en_q.sec);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      sec_q <= 1'b1;
    end else begin
      en_q  <= en_d;
      sec_q <= sec_d;
    end
  end

  always_comb begin
    stat.rx  = rx_req_i;
    stat.tx  = tx_req_i;
    stat.sec = sec_q;
  end

  assign en_o   = en_q;
  assign stat_o = stat;
  assign irq_o  = |(stat & en_q);

  // R9
  sec_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_q.sec) |=> sec_q);

  // R7
  sec_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_q && !en_q.sec) |=> !sec_q);
endmodule

// File: rtl/frm_irq_agg.sv
module frm_irq_agg
  import frm_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RX_N   = 8,
  parameter int TX_N   = 8,
  parameter int CLK_HZ = 25_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_en_i,
  output logic [7:0]        rd_data_o,
  input  logic [RX_N-1:0]   rx_evt_i,
  input  logic [TX_N-1:0]   tx_evt_i,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] AD_BLK_EN = ADDR_W'(A_BLK_EN);
  localparam logic [ADDR_W-1:0] AD_BLK_ST = ADDR_W'(A_BLK_ST);
  localparam logic [ADDR_W-1:0] AD_RX_EN  = ADDR_W'(A_RX_EN);
  localparam logic [ADDR_W-1:0] AD_RX_ST  = ADDR_W'(A_RX_ST);
  localparam logic [ADDR_W-1:0] AD_TX_EN  = ADDR_W'(A_TX_EN);
  localparam logic [ADDR_W-1:0] AD_TX_ST  = ADDR_W'(A_TX_ST);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // decode
  logic wr_blk_en, wr_rx_en, wr_tx_en;
  logic clr_blk, clr_rx, clr_tx;

  always_comb begin
    wr_blk_en = wr_en_i && (addr_i == AD_BLK_EN);
    wr_rx_en  = wr_en_i && (addr_i == AD_RX_EN);
    wr_tx_en  = wr_en_i && (addr_i == AD_TX_EN);
    clr_blk   = rd_en_i && (addr_i == AD_BLK_ST);
    clr_rx    = rd_en_i && (addr_i == AD_RX_ST);
    clr_tx    = rd_en_i && (addr_i == AD_TX_ST);
  end

  logic tick;

  frm_irq_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tick_o (tick)
  );

  logic [RX_N-1:0] rx_en, rx_pend;
  logic [TX_N-1:0] tx_en, tx_pend;
  logic            rx_req, tx_req;

  frm_irq_src #(.N(RX_N)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .evt_i      (rx_evt_i),
    .en_wr_i    (wr_rx_en),
    .en_wdata_i (wr_data_i[RX_N-1:0]),
    .rd_clr_i   (clr_rx),
    .en_o       (rx_en),
    .pend_o     (rx_pend),
    .req_o      (rx_req)
  );

  frm_irq_src #(.N(TX_N)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .evt_i      (tx_evt_i),
    .en_wr_i    (wr_tx_en),
    .en_wdata_i (wr_data_i[TX_N-1:0]),
    .rd_clr_i   (clr_tx),
    .en_o       (tx_en),
    .pend_o     (tx_pend),
    .req_o      (tx_req)
  );

  blk_bits_t blk_en, blk_stat;
  logic      irq;

  frm_irq_blk u_blk (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .en_wr_i    (wr_blk_en),
    .en_wdata_i (unpack_blk(wr_data_i)),
    .tick_i     (tick),
    .rd_clr_i   (clr_blk),
    .rx_req_i   (rx_req),
    .tx_req_i   (tx_req),
    .en_o       (blk_en),
    .stat_o     (blk_stat),
    .irq_o      (irq)
  );

  // read port
  logic [7:0] rd_mux, rd_q, rd_d;

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      AD_BLK_EN: rd_mux = pack_blk(blk_en);
      AD_BLK_ST: rd_mux = pack_blk(blk_stat);
      AD_RX_EN:  rd_mux = 8'(rx_en);
      AD_RX_ST:  rd_mux = 8'(rx_pend);
      AD_TX_EN:  rd_mux = 8'(tx_en);
      AD_TX_ST:  rd_mux = 8'(tx_pend);
      default:   rd_mux = '0;
    endcase
    rd_d = rd_en_i ? rd_mux : rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;
  assign irq_o     = irq;

  // R6
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(irq_o) |-> (blk_en != '0));

  // R11
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: tb/frm_irq_agg_bench.sv
module frm_irq_agg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HZ   = 16;
  localparam int RXN  = 8;
  localparam int TXN  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [RXN-1:0] rx_evt = '0;
  logic [TXN-1:0] tx_evt = '0;
  logic irq;

  int n_run = 0, n_fail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frm_irq_agg #(.ADDR_W(8), .RX_N(RXN), .TX_N(TXN), .CLK_HZ(HZ)) u_frm_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wdata),
    .rd_en_i(rd_en), .rd_data_o(rdata), .rx_evt_i(rx_evt), .tx_evt_i(tx_evt), .irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse_rx(logic [RXN-1:0] v);
    rx_evt = v; @(negedge clk); rx_evt = '0;
  endtask

  task automatic pulse_tx(logic [TXN-1:0] v);
    tx_evt = v; @(negedge clk); tx_evt = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h05, d); chk("R1 status", d, 8'h01);
    rd(8'h04, d); chk("R1 blk en", d, 8'h00);
    rd(8'h10, d); chk("R1 rx en", d, 8'h00);
    rd(8'h12, d); chk("R1 tx en", d, 8'h00);
    chk("R1 irq", irq, 0);
    rd(8'h05, d); chk("R7 read clears bit0", d, 8'h00);
  endtask

  task automatic t_enables();
    logic [7:0] d;
    wr(8'h10, 8'hA5); rd(8'h10, d); chk("R11 rx en readback", d, 8'hA5);
    wr(8'h12, 8'h06); rd(8'h12, d); chk("R11 tx en readback", d, 8'h06);
    wr(8'h04, 8'h82); rd(8'h04, d); chk("R11 blk en readback", d, 8'h82);
    @(negedge clk); @(negedge clk);
    chk("R11 read data held", rdata, 8'h82);
    wr(8'h10, 8'h00); wr(8'h12, 8'h00); wr(8'h04, 8'h00);
  endtask

  task automatic t_rx();
    logic [7:0] d;
    wr(8'h10, 8'h04); wr(8'h04, 8'h80);
    pulse_rx(8'h04);
    chk("R3 irq on rx", irq, 1);
    rd(8'h05, d); chk("R3 summary bit7", d & 8'h82, 8'h80);
    rd(8'h11, d); chk("R3 pending read", d, 8'h04);
    rd(8'h05, d); chk("R3 summary cleared", d & 8'h82, 8'h00);
    chk("R3 irq cleared", irq, 0);
    pulse_rx(8'h08);
    rd(8'h11, d); chk("R5 masked rx not latched", d, 8'h00);
    chk("R5 irq stays low", irq, 0);
  endtask

  task automatic t_tx();
    logic [7:0] d;
    wr(8'h12, 8'h01); wr(8'h04, 8'h02);
    pulse_tx(4'h1);
    rd(8'h05, d); chk("R4 summary bit1", d & 8'h82, 8'h02);
    chk("R4 irq on tx", irq, 1);
    rd(8'h13, d); chk("R4 pending read", d, 8'h01);
    rd(8'h05, d); chk("R4 summary cleared", d & 8'h82, 8'h00);
    pulse_tx(4'h2);
    rd(8'h05, d); chk("R5 masked tx summary", d & 8'h82, 8'h00);
    wr(8'h12, 8'h00); wr(8'h04, 8'h00);
  endtask

  task automatic t_veto();
    logic [7:0] d;
    wr(8'h10, 8'h01);
    pulse_rx(8'h01);
    rd(8'h05, d); chk("R6 summary without blk en", d & 8'h80, 8'h80);
    chk("R6 veto by blk en", irq, 0);
    wr(8'h04, 8'h80);
    chk("R6 irq after blk en", irq, 1);
    rd(8'h11, d);
    wr(8'h10, 8'h00);
    pulse_rx(8'h01);
    chk("R6 blk en cannot force source", irq, 0);
    wr(8'h04, 8'h00);
  endtask

  task automatic t_coinc_src();
    logic [7:0] d;
    wr(8'h10, 8'h03);
    pulse_rx(8'h01);
    rx_evt = 8'h02;
    rd(8'h11, d);
    rx_evt = '0;
    chk("R10 read returns old", d, 8'h01);
    rd(8'h11, d); chk("R10 new event kept", d, 8'h02);
    rd(8'h11, d); chk("R10 then empty", d, 8'h00);
    wr(8'h10, 8'h00);
  endtask

  task automatic t_second();
    logic [7:0] d;
    int c1, c2, lim;
    wr(8'h04, 8'h01);
    rd(8'h05, d);
    lim = 0;
    while (!irq && lim < 3*HZ) begin @(negedge clk); lim++; end
    c1 = cyc;
    chk("R7 bit0 set while enabled", irq, 1);
    rd(8'h05, d); chk("R7 read sees bit0", d, 8'h01);
    chk("R7 cleared after read", irq, 0);
    lim = 0;
    while (!irq && lim < 3*HZ) begin @(negedge clk); lim++; end
    c2 = cyc;
    chk("R8 tick spacing", c2 - c1, HZ);
    rd(8'h05, d);
    while (cyc != c2 + HZ - 1) @(negedge clk);
    rd(8'h05, d);
    chk("R9 coincident read value", d & 8'h01, 8'h00);
    chk("R9 bit0 survives", irq, 1);
    rd(8'h05, d); chk("R9 next read sees bit0", d, 8'h01);
    wr(8'h04, 8'h00);
    rd(8'h05, d);
    repeat (3*HZ) @(negedge clk);
    rd(8'h05, d); chk("R7 no tick when disabled", d, 8'h00);
    chk("R7 irq low when disabled", irq, 0);
    wr(8'h05, 8'hFF);
    rd(8'h05, d); chk("R2 write ignored, unused zero", d, 8'h00);
    wr(8'h10, 8'hFF); pulse_rx(8'hFF); wr(8'h12, 8'hF); pulse_tx(4'hF);
    rd(8'h05, d); chk("R2 unused bits zero", d & 8'h7C, 8'h00);
    rd(8'h11, d); rd(8'h13, d);
    wr(8'h10, 8'h00); wr(8'h12, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enables();
    t_rx();
    t_tx();
    t_veto();
    t_coinc_src();
    t_second();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule